// File: doc/BRIEF.md
# Fast PWM Timer with Selectable Ceiling

This block is a 16-bit single-slope timer/counter for fast PWM. On every timer tick (a one-cycle enable from an external prescaler) the counter steps up by one. When it reaches its ceiling it returns to zero on the following tick. Two compare channels, A and B, each compare the count against their own active compare value and drive a PWM pin. The pin can be non-inverted, inverted or disconnected.

A 4-bit mode input selects the ceiling from five sources. Three are fixed resolutions of 8, 9 and 10 bits. The fourth is a capture register that is written directly and takes effect at once. The fifth is the active compare value of channel A, which is double buffered. Because the capture register is unbuffered, lowering it below the running count makes the counter miss its ceiling and run on to the all-ones value before it wraps. The compare values of both channels are written into buffers, and the buffers are copied into the active registers only in the tick where the counter restarts. Four sticky flags report the ceiling, the compare events and the capture-ceiling events. Each flag is cleared by a write-one strobe.

Top module: `fpwm_timer`

## Requirements
- R1: While rst_ni is low and after its release, count_o is 0 and all four flags are 0. The active and buffered compare values and the capture register are 0.
- R2: The ceiling is 0x00FF for mode_i=5, 0x01FF for mode_i=6, 0x03FF for mode_i=7, the capture register for mode_i=14, the active channel-A compare value for mode_i=15, and 0xFFFF for any other code. When tick_i=1 and the count differs from the ceiling, the count increments by one and wraps from 0xFFFF to 0. When tick_i=0 the count holds.
- R3: In a cycle where tick_i=1 and count_o equals the ceiling, count_o becomes 0 and ovf_flag_o becomes 1 after the edge.
- R4: In mode 14, cap_flag_o is set in the same edge as ovf_flag_o. In mode 15, cmpa_flag_o is set in that edge too, because the channel-A match occurs at the ceiling.
- R5: A write to the capture register (icr_we_i) takes effect at the next edge. If the new value is below the running count, no ceiling event happens until the count passes 0xFFFF, wraps to 0 and climbs to the new value.
- R6: Writes to ocra_we_i and ocrb_we_i load a buffer. The active compare value loads from the buffer only in a ceiling tick (R3). Until then, the old value still sets the compare point and, in mode 15, the ceiling.
- R7: When a compare buffer is written in modes 5, 6 and 7, the bits above 8, 9 and 10 bits respectively are stored as zero. In all other modes the written value is stored whole.
- R8: A raw waveform per channel is set to 1 on a restart tick (a ceiling tick, or a tick at 0xFFFF) and cleared to 0 on a match tick, with restart winning when both occur. A compare-output mode of 2 drives the waveform to the pin and a mode of 3 drives its complement. Modes 0 and 1 drive the pin low. With mode 2 and compare value C, the pin is 1 while count_o is between 0 and C inclusive.
- R9: A channel's compare flag (cmpa_flag_o, cmpb_flag_o) is set after a tick where count_o equals that channel's active compare value. A compare value above the ceiling never sets it.
- R10: flag_clr_i bit 0 clears ovf_flag_o, bit 1 clears cmpa_flag_o, bit 2 clears cmpb_flag_o and bit 3 clears cap_flag_o. A set in the same edge wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer tick enable from the prescaler |
| mode_i | input | 4 | Waveform mode; selects the ceiling source |
| icr_we_i | input | 1 | Write strobe for the capture register |
| ocra_we_i | input | 1 | Write strobe for the channel-A compare buffer |
| ocrb_we_i | input | 1 | Write strobe for the channel-B compare buffer |
| wdata_i | input | 16 | Write data shared by the three registers |
| com_a_i | input | 2 | Channel-A compare-output mode |
| com_b_i | input | 2 | Channel-B compare-output mode |
| flag_clr_i | input | 4 | Write-one-to-clear strobes for the flags |
| count_o | output | 16 | Current count |
| pwm_a_o | output | 1 | Channel-A PWM pin |
| pwm_b_o | output | 1 | Channel-B PWM pin |
| ovf_flag_o | output | 1 | Ceiling (overflow) flag |
| cmpa_flag_o | output | 1 | Channel-A compare flag |
| cmpb_flag_o | output | 1 | Channel-B compare flag |
| cap_flag_o | output | 1 | Capture-ceiling flag |

## Verification
The bench lowers the capture register below a running count. A design that buffered that register, or clamped the count, would restart early instead of running through 0xFFFF with the overflow flag clear. It rewrites the channel-A buffer in mid-period under mode 15. A design that loaded the value at once would cut that period short and never reach the old ceiling. It writes an out-of-range compare value in 8-bit mode, so a design that skipped masking would never match. It also sets a compare value above the ceiling, where any spurious flag shows up. Around these cases, a long run of random ticks, writes, mode changes and clears is compared each cycle against a cycle model of the count, flags and pins, which catches errors in duty cycle, inversion or flag priority.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam logic [3:0] MODE_FIX_BASE = 4'd5;
  localparam int         NUM_FIX       = 3;
  localparam int         FIX_MIN_BITS  = 8;
  localparam logic [3:0] MODE_ICR      = 4'd14;
  localparam logic [3:0] MODE_OCRA     = 4'd15;

  typedef enum logic [1:0] {
    COM_OFF    = 2'd0,
    COM_RSVD   = 2'd1,
    COM_NONINV = 2'd2,
    COM_INV    = 2'd3
  } com_e;

  localparam int FLG_OVF  = 0;
  localparam int FLG_CMPA = 1;
  localparam int FLG_CMPB = 2;
  localparam int FLG_CAP  = 3;
  localparam int NUM_FLG  = 4;
endpackage

// File: rtl/fpwm_top_sel.sv
module fpwm_top_sel
  import fpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   mode_i,
  input  logic [W-1:0] icr_i,
  input  logic [W-1:0] ocra_act_i,
  output logic [W-1:0] top_o,
  output logic [W-1:0] mask_o
);
  always_comb begin
    top_o  = '1;
    mask_o = '1;
    for (int k = 0; k < NUM_FIX; k++) begin
      if (mode_i == 4'(MODE_FIX_BASE + 4'(k))) begin
        top_o  = W'((1 << (FIX_MIN_BITS + k)) - 1);
        mask_o = top_o;
      end
    end
    if (mode_i == MODE_ICR)  top_o = icr_i;
    if (mode_i == MODE_OCRA) top_o = ocra_act_i;
  end
endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] top_i,
  input  logic         cap_mode_i,
  input  logic         clr_ovf_i,
  input  logic         clr_cap_i,
  output logic [W-1:0] cnt_o,
  output logic         top_hit_o,
  output logic         bottom_o,
  output logic         ovf_o,
  output logic         cap_o
);
  logic [W-1:0] cnt_q;
  logic         ovf_q, cap_q;
  logic         at_max;

  assign at_max    = (cnt_q == '1);
  assign top_hit_o = tick_i && (cnt_q == top_i);
  // restart also on a wrap past a missed ceiling
  assign bottom_o  = tick_i && ((cnt_q == top_i) || at_max);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == top_i) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      cap_q <= 1'b0;
    end else begin
      if (top_hit_o)      ovf_q <= 1'b1;
      else if (clr_ovf_i) ovf_q <= 1'b0;
      if (top_hit_o && cap_mode_i) cap_q <= 1'b1;
      else if (clr_cap_i)          cap_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
  assign cap_o = cap_q;
endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel
  import fpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] cnt_i,
  input  logic         top_hit_i,
  input  logic         bottom_i,
  input  logic [1:0]   com_i,
  input  logic         clr_i,
  output logic         pwm_o,
  output logic         flag_o,
  output logic [W-1:0] ocr_o
);
  logic [W-1:0] buf_q, act_q;
  logic         wave_q, flag_q, match;

  assign match = tick_i && (cnt_i == act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (we_i)      buf_q <= wdata_i & mask_i;
      if (top_hit_i) act_q <= buf_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (bottom_i)   wave_q <= 1'b1;
      else if (match) wave_q <= 1'b0;
      if (match)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (com_e'(com_i))
      COM_NONINV: pwm_o = wave_q;
      COM_INV:    pwm_o = ~wave_q;
      default:    pwm_o = 1'b0;
    endcase
  end

  assign flag_o = flag_q;
  assign ocr_o  = act_q;
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [3:0]         mode_i,
  input  logic               icr_we_i,
  input  logic               ocra_we_i,
  input  logic               ocrb_we_i,
  input  logic [W-1:0]       wdata_i,
  input  logic [1:0]         com_a_i,
  input  logic [1:0]         com_b_i,
  input  logic [NUM_FLG-1:0] flag_clr_i,
  output logic [W-1:0]       count_o,
  output logic               pwm_a_o,
  output logic               pwm_b_o,
  output logic               ovf_flag_o,
  output logic               cmpa_flag_o,
  output logic               cmpb_flag_o,
  output logic               cap_flag_o
);
  logic [W-1:0] icr_q, top_w, mask_w, ocra_act, ocrb_act, cnt_w;
  logic         top_hit, bottom;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       icr_q <= '0;
    else if (icr_we_i) icr_q <= wdata_i;
  end

  fpwm_top_sel #(.W(W)) u_top_sel (
    .mode_i     (mode_i),
    .icr_i      (icr_q),
    .ocra_act_i (ocra_act),
    .top_o      (top_w),
    .mask_o     (mask_w)
  );

  fpwm_counter #(.W(W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .top_i      (top_w),
    .cap_mode_i (mode_i == MODE_ICR),
    .clr_ovf_i  (flag_clr_i[FLG_OVF]),
    .clr_cap_i  (flag_clr_i[FLG_CAP]),
    .cnt_o      (cnt_w),
    .top_hit_o  (top_hit),
    .bottom_o   (bottom),
    .ovf_o      (ovf_flag_o),
    .cap_o      (cap_flag_o)
  );

  fpwm_channel #(.W(W)) u_ch_a (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .we_i      (ocra_we_i),
    .wdata_i   (wdata_i),
    .mask_i    (mask_w),
    .cnt_i     (cnt_w),
    .top_hit_i (top_hit),
    .bottom_i  (bottom),
    .com_i     (com_a_i),
    .clr_i     (flag_clr_i[FLG_CMPA]),
    .pwm_o     (pwm_a_o),
    .flag_o    (cmpa_flag_o),
    .ocr_o     (ocra_act)
  );

  fpwm_channel #(.W(W)) u_ch_b (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .we_i      (ocrb_we_i),
    .wdata_i   (wdata_i),
    .mask_i    (mask_w),
    .cnt_i     (cnt_w),
    .top_hit_i (top_hit),
    .bottom_i  (bottom),
    .com_i     (com_b_i),
    .clr_i     (flag_clr_i[FLG_CMPB]),
    .pwm_o     (pwm_b_o),
    .flag_o    (cmpb_flag_o),
    .ocr_o     (ocrb_act)
  );

  assign count_o = cnt_w;

  logic unused_b;
  assign unused_b = ^ocrb_act;
endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic [1:0]   com_a_i,
  input logic [3:0]   flag_clr_i,
  input logic [W-1:0] count_o,
  input logic [W-1:0] top_i,
  input logic         pwm_a_o,
  input logic         ovf_flag_o,
  input logic         cap_flag_o
);
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && count_o != top_i |=> count_o == $past(count_o) + 1'b1);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && count_o == top_i |=> count_o == '0);

  p_ovf_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && count_o == top_i |=> ovf_flag_o);

  p_cap_with_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_flag_o) |-> ovf_flag_o);

  p_bottom_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && count_o == top_i && com_a_i == 2'd2 |=> com_a_i != 2'd2 || pwm_a_o);

  p_ovf_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i[0] && !(tick_i && count_o == top_i) |=> !ovf_flag_o);
endmodule

bind fpwm_timer fpwm_timer_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .com_a_i    (com_a_i),
  .flag_clr_i (flag_clr_i),
  .count_o    (count_o),
  .top_i      (top_w),
  .pwm_a_o    (pwm_a_o),
  .ovf_flag_o (ovf_flag_o),
  .cap_flag_o (cap_flag_o)
);

// File: tb/fpwm_timer_test.sv
`timescale 1ns/1ps
module fpwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic        icr_we = 1'b0, ocra_we = 1'b0, ocrb_we = 1'b0;
  logic [15:0] wdata = '0;
  logic [1:0]  com_a = 2'd0, com_b = 2'd0;
  logic [3:0]  fclr = 4'd0;
  logic [15:0] count;
  logic        pwm_a, pwm_b, f_ovf, f_cmpa, f_cmpb, f_cap;

  always #2 clk = ~clk;

  fpwm_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_i(mode),
    .icr_we_i(icr_we), .ocra_we_i(ocra_we), .ocrb_we_i(ocrb_we),
    .wdata_i(wdata), .com_a_i(com_a), .com_b_i(com_b), .flag_clr_i(fclr),
    .count_o(count), .pwm_a_o(pwm_a), .pwm_b_o(pwm_b),
    .ovf_flag_o(f_ovf), .cmpa_flag_o(f_cmpa), .cmpb_flag_o(f_cmpb),
    .cap_flag_o(f_cap)
  );

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] f_top(logic [3:0] md, logic [15:0] acta, logic [15:0] icr);
    case (md)
      4'd5:    return 16'h00FF;
      4'd6:    return 16'h01FF;
      4'd7:    return 16'h03FF;
      4'd14:   return icr;
      4'd15:   return acta;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] f_mask(logic [3:0] md);
    case (md)
      4'd5:    return 16'h00FF;
      4'd6:    return 16'h01FF;
      4'd7:    return 16'h03FF;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic f_pin(logic [1:0] com, logic w);
    if (com == 2'd2) return w;
    if (com == 2'd3) return ~w;
    return 1'b0;
  endfunction

  // cycle model built from the requirements
  logic [15:0] m_cnt, m_icr, m_bufa, m_bufb, m_acta, m_actb;
  logic        m_wa, m_wb;
  logic [3:0]  m_f;

  always @(posedge clk or negedge rst_n) begin
    logic [15:0] t, msk;
    logic hit, wr, ma, mb;
    if (!rst_n) begin
      m_cnt = '0; m_icr = '0; m_bufa = '0; m_bufb = '0;
      m_acta = '0; m_actb = '0; m_wa = 1'b0; m_wb = 1'b0; m_f = '0;
    end else begin
      t   = f_top(mode, m_acta, m_icr);
      msk = f_mask(mode);
      hit = tick && (m_cnt == t);
      wr  = tick && (m_cnt == 16'hFFFF);
      ma  = tick && (m_cnt == m_acta);
      mb  = tick && (m_cnt == m_actb);
      m_f = m_f & ~fclr;
      if (hit) m_f[0] = 1'b1;
      if (ma)  m_f[1] = 1'b1;
      if (mb)  m_f[2] = 1'b1;
      if (hit && mode == 4'd14) m_f[3] = 1'b1;
      if (hit || wr) m_wa = 1'b1; else if (ma) m_wa = 1'b0;
      if (hit || wr) m_wb = 1'b1; else if (mb) m_wb = 1'b0;
      if (hit) begin m_acta = m_bufa; m_actb = m_bufb; end
      if (ocra_we) m_bufa = wdata & msk;
      if (ocrb_we) m_bufb = wdata & msk;
      if (icr_we)  m_icr  = wdata;
      if (tick) m_cnt = hit ? 16'h0000 : m_cnt + 16'd1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk("R2 count", 32'(count), 32'(m_cnt));
      chk("R3 ovf flag", 32'(f_ovf), 32'(m_f[0]));
      chk("R9 cmpa flag", 32'(f_cmpa), 32'(m_f[1]));
      chk("R9 cmpb flag", 32'(f_cmpb), 32'(m_f[2]));
      chk("R4 cap flag", 32'(f_cap), 32'(m_f[3]));
      chk("R8 pwm a", 32'(pwm_a), 32'(f_pin(com_a, m_wa)));
      chk("R8 pwm b", 32'(pwm_b), 32'(f_pin(com_b, m_wb)));
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input int sel, input logic [15:0] d);
    wdata = d;
    icr_we = (sel == 0); ocra_we = (sel == 1); ocrb_we = (sel == 2);
    step();
    icr_we = 1'b0; ocra_we = 1'b0; ocrb_we = 1'b0;
  endtask

  task automatic clr_pulse(input logic [3:0] m);
    fclr = m;
    step();
    fclr = 4'd0;
  endtask

  task automatic wait_cnt(input logic [15:0] v, input int maxn, output bit found);
    found = 1'b0;
    for (int i = 0; i < maxn && !found; i++) begin
      if (count == v) found = 1'b1;
      else step();
    end
    if (!found && count == v) found = 1'b1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    bit f;
    logic [15:0] c;
    void'($urandom(32'd20240611));
    repeat (3) step();
    // R1 reset state
    chk("R1 count in reset", 32'(count), 32'd0);
    chk("R1 flags in reset", 32'({f_ovf, f_cmpa, f_cmpb, f_cap}), 32'd0);
    rst_n = 1'b1;
    model_on = 1'b1;
    step();
    chk("R1 count after reset", 32'(count), 32'd0);
    chk("R1 flags after reset", 32'({f_ovf, f_cmpa, f_cmpb, f_cap}), 32'd0);

    // R6 buffered channel-A ceiling in mode 15
    mode = 4'd15; tick = 1'b1;
    wr_reg(1, 16'h0040);
    wait_cnt(16'h0010, 200, f);
    chk("R6 reach 0x10", 32'(f), 32'd1);
    wr_reg(1, 16'h0020);
    wait_cnt(16'h0030, 100, f);
    chk("R6 old ceiling kept", 32'(f), 32'd1);
    wait_cnt(16'h0000, 100, f);
    wait_cnt(16'h0020, 100, f);
    step();
    chk("R6 new ceiling", 32'(count), 32'd0);
    chk("R4 cmpa with ovf in mode 15", 32'({f_ovf, f_cmpa}), 32'h3);

    // R10 clear strobes and R2 hold
    tick = 1'b0;
    c = count;
    clr_pulse(4'hF);
    chk("R10 flags cleared", 32'({f_ovf, f_cmpa, f_cmpb, f_cap}), 32'd0);
    repeat (3) step();
    chk("R2 hold without tick", 32'(count), 32'(c));

    // R8 waveform polarity in mode 5
    mode = 4'd5; tick = 1'b1; com_a = 2'd2;
    wr_reg(1, 16'h0010);
    wait_cnt(16'h0000, 300, f);
    wait_cnt(16'h0010, 300, f);
    chk("R8 high at compare value", 32'(pwm_a), 32'd1);
    step();
    chk("R8 low after match", 32'(pwm_a), 32'd0);
    com_a = 2'd3; #0.5;
    chk("R8 inverted", 32'(pwm_a), 32'd1);
    com_a = 2'd1; #0.5;
    chk("R8 disconnected low", 32'(pwm_a), 32'd0);
    com_a = 2'd2;

    // R7 masking of an out-of-range compare value
    wr_reg(2, 16'h0150);
    wait_cnt(16'h0000, 300, f);
    clr_pulse(4'h4);
    wait_cnt(16'h0050, 300, f);
    chk("R7 no match before 0x50", 32'(f_cmpb), 32'd0);
    step();
    chk("R7 masked compare matches", 32'(f_cmpb), 32'd1);

    // R9 compare value above ceiling
    mode = 4'd14;
    wr_reg(0, 16'h0080);
    wr_reg(2, 16'h0090);
    wait_cnt(16'h0000, 300, f);
    step();
    wait_cnt(16'h0000, 300, f);
    clr_pulse(4'hF);
    repeat (3 * 16'h81) step();
    chk("R9 no match above ceiling", 32'(f_cmpb), 32'd0);
    chk("R4 cap flag in mode 14", 32'(f_cap), 32'd1);

    // R5 unbuffered capture register missed ceiling
    wait_cnt(16'h0000, 300, f);
    wr_reg(0, 16'h0300);
    wait_cnt(16'h0200, 16'h0400, f);
    chk("R5 reach 0x200", 32'(f), 32'd1);
    wr_reg(0, 16'h0100);
    clr_pulse(4'hF);
    wait_cnt(16'hFFFF, 70000, f);
    chk("R5 ran to 0xFFFF", 32'(f), 32'd1);
    chk("R5 no ceiling event", 32'(f_ovf), 32'd0);
    step();
    chk("R5 wrapped to 0", 32'(count), 32'd0);
    repeat (16'h0100) step();
    chk("R5 climbs to new ceiling", 32'(count), 32'h0100);
    step();
    chk("R5 restart at new ceiling", 32'(count), 32'd0);
    chk("R5 ovf at new ceiling", 32'(f_ovf), 32'd1);
    chk("R4 cap with ovf", 32'(f_cap), 32'd1);

    // random phase checked against the cycle model
    com_b = 2'd3;
    for (int i = 0; i < 20000; i++) begin
      tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 399) == 0) begin
        case ($urandom_range(0, 5))
          0: mode = 4'd5;
          1: mode = 4'd6;
          2: mode = 4'd7;
          3: mode = 4'd14;
          4: mode = 4'd15;
          default: mode = 4'd0;
        endcase
      end
      wdata   = ($urandom_range(0, 7) == 0) ? 16'($urandom) : 16'($urandom & 32'h03FF);
      icr_we  = ($urandom_range(0, 63) == 0);
      ocra_we = ($urandom_range(0, 63) == 0);
      ocrb_we = ($urandom_range(0, 63) == 0);
      if ($urandom_range(0, 199) == 0) com_a = 2'($urandom);
      if ($urandom_range(0, 199) == 0) com_b = 2'($urandom);
      fclr = ($urandom_range(0, 49) == 0) ? 4'($urandom) : 4'd0;
      step();
    end
    icr_we = 1'b0; ocra_we = 1'b0; ocrb_we = 1'b0; fclr = 4'd0;
    step();
    finish_run();
  end
endmodule